// File: doc/BRIEF.md
# Multi-mode 8-bit waveform timer

This block is an 8-bit timer/counter that serves as a free-running counter, as a period timer that clears on a compare value, or as a pulse-width generator. It has a fast single-slope variant and a symmetric up/down variant. A 3-bit mode input selects how the counter runs. The mode also sets the ceiling (TOP): either fixed at 0xFF or taken from compare value A. The same input sets when the compare values take effect and the point at which the overflow flag is raised.

The counter moves only on cycles where `tick` is high, so a prescaler can sit outside the block. In the pulse-width modes both compare values are double-buffered. A new value on `cmp_a` or `cmp_b` becomes active only at a defined point in the period, so a period is never cut short. A 2-bit output mode sets how `pin_b` reacts to a match on compare B. When the pin is disconnected, `pin_oe` is low and `pin_b` reads 0.

Top module: `timer8_wavegen`

## Requirements
- R1: The counter changes only on cycles with `tick` high. In mode 0 and in the reserved modes 4 and 6 it steps by one and wraps from 0xFF to 0x00.
- R2: In mode 2 the counter runs from 0 up to `cmp_a`, and the tick taken at that value returns it to 0.
- R3: Fast modes (3: TOP = 0xFF, 7: TOP = active A) count up and wrap from TOP to 0.
- R4: Phase-correct modes (1: TOP = 0xFF, 5: TOP = active A) count up to TOP and then down to 0, with no end value repeated. If TOP is 0 the counter holds at 0.
- R5: In modes 0, 2, 4 and 6 the values on `cmp_a`/`cmp_b` act at once. In modes 1, 3, 5 and 7 they are copied to the active registers on the tick taken at TOP. Active registers reset to 0.
- R6: `ovf_flag` is set by the tick leaving 0xFF in modes 0, 2, 3, 4 and 6, by the tick leaving TOP in mode 7, and by the tick leaving 0 while counting down in modes 1 and 5. It holds until `ovf_clr` is high; a set in the same cycle wins over a clear.
- R7: Fast modes: with `com_b` = 2, a tick at TOP sets the pin; otherwise a tick at compare B clears it. With `com_b` = 3, the same two events clear and set the pin instead.
- R8: Phase-correct modes: on a tick at compare B, `com_b` = 2 clears the pin if the step taken is upward and sets it if downward; `com_b` = 3 does the opposite. The step from 0 counts as upward and the step from TOP as downward.
- R9: Phase-correct modes with active B equal to TOP and `com_b[1]` high: at TOP the pin is set for `com_b` = 2 and cleared for `com_b` = 3, giving a constant level.
- R10: Modes 0 and 2: on a tick at compare B, `com_b` = 1 toggles the pin, 2 clears it and 3 sets it. The pin is disconnected (`pin_oe` = 0, `pin_b` = 0) for `com_b` = 0, for `com_b` = 1 in the fast and phase-correct modes, and in modes 4 and 6.
- R11: After reset `count` is 0, `ovf_flag` is 0, and the pin level is 0 with the counter direction upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 3 | Waveform mode select (encoding in R1 to R6) |
| cmp_a | input | 8 | Compare value A (TOP source in modes 2, 5, 7) |
| cmp_b | input | 8 | Compare value B (pin B events) |
| com_b | input | 2 | Output mode for pin B |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current counter value |
| pin_b | output | 1 | Waveform output B (0 when disconnected) |
| pin_oe | output | 1 | High when the block drives pin B |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result is registered, so a tick taken at a rising edge shows on `count`, `pin_b` and `ovf_flag` right after that edge. Nothing is visible at the edge where the tick is applied. The internal reset release adds two more edges after `rst_n` rises, and the bench waits three edges before its first tick. Each case holds `tick` high for exactly N edges and samples at the next falling edge. The expected counter value, pin level and flag are therefore worked out for the state after the Nth tick. That includes the first period of a buffered mode, which still runs with the reset values of the active compare registers.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    SEQ_FREE,
    SEQ_CLEAR_AT_TOP,
    SEQ_UPDOWN
  } seq_e;

  typedef enum logic [1:0] {
    OVF_AT_MAX,
    OVF_AT_TOP,
    OVF_AT_BOTTOM
  } ovf_e;

  typedef enum logic [1:0] {
    WAVE_NONPWM,
    WAVE_FAST,
    WAVE_PHASE,
    WAVE_OFF
  } wave_e;

  typedef struct packed {
    seq_e  seq;
    ovf_e  ovf;
    wave_e wave;
    logic  top_from_a;
    logic  buffered;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [2:0] m);
    mode_cfg_t c;
    c = '{seq: SEQ_FREE, ovf: OVF_AT_MAX, wave: WAVE_OFF, top_from_a: 1'b0, buffered: 1'b0};
    case (m)
      3'd0: c = '{seq: SEQ_FREE,         ovf: OVF_AT_MAX,    wave: WAVE_NONPWM, top_from_a: 1'b0, buffered: 1'b0};
      3'd1: c = '{seq: SEQ_UPDOWN,       ovf: OVF_AT_BOTTOM, wave: WAVE_PHASE,  top_from_a: 1'b0, buffered: 1'b1};
      3'd2: c = '{seq: SEQ_CLEAR_AT_TOP, ovf: OVF_AT_MAX,    wave: WAVE_NONPWM, top_from_a: 1'b1, buffered: 1'b0};
      3'd3: c = '{seq: SEQ_CLEAR_AT_TOP, ovf: OVF_AT_MAX,    wave: WAVE_FAST,   top_from_a: 1'b0, buffered: 1'b1};
      3'd5: c = '{seq: SEQ_UPDOWN,       ovf: OVF_AT_BOTTOM, wave: WAVE_PHASE,  top_from_a: 1'b1, buffered: 1'b1};
      3'd7: c = '{seq: SEQ_CLEAR_AT_TOP, ovf: OVF_AT_TOP,    wave: WAVE_FAST,   top_from_a: 1'b1, buffered: 1'b1};
      default: c = '{seq: SEQ_FREE,      ovf: OVF_AT_MAX,    wave: WAVE_OFF,    top_from_a: 1'b0, buffered: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/timer8_mode_decode.sv
module timer8_mode_decode
  import timer8_pkg::*;
(
  input  logic [2:0] mode,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = decode_mode(mode);
  end

endmodule

// File: rtl/timer8_cmp_regs.sv
module timer8_cmp_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         buffered,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] eff_a,
  output logic [W-1:0] eff_b
);

  logic [W-1:0] act_a_q, act_a_d;
  logic [W-1:0] act_b_q, act_b_d;
  logic         take;

  always_comb begin
    take    = load || !buffered;
    act_a_d = take ? cmp_a : act_a_q;
    act_b_d = take ? cmp_b : act_b_q;
    eff_a   = buffered ? act_a_q : cmp_a;
    eff_b   = buffered ? act_b_q : cmp_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q <= '0;
      act_b_q <= '0;
    end else begin
      act_a_q <= act_a_d;
      act_b_q <= act_b_d;
    end
  end

endmodule

// File: rtl/timer8_counter.sv
module timer8_counter
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  seq_e         seq,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         step_up,
  output logic         at_top,
  output logic         at_bottom
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    at_top    = (cnt_q == top);
    at_bottom = (cnt_q == '0);
    if (seq == SEQ_UPDOWN) begin
      step_up = at_bottom ? 1'b1 : (at_top ? 1'b0 : up_q);
    end else begin
      step_up = 1'b1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      case (seq)
        SEQ_CLEAR_AT_TOP: begin
          cnt_d = at_top ? '0 : cnt_q + ONE;
          up_d  = 1'b1;
        end
        SEQ_UPDOWN: begin
          if (top == '0) begin
            cnt_d = '0;
            up_d  = 1'b1;
          end else if (at_top) begin
            cnt_d = cnt_q - ONE;
            up_d  = 1'b0;
          end else if (at_bottom) begin
            cnt_d = ONE;
            up_d  = 1'b1;
          end else begin
            cnt_d = up_q ? cnt_q + ONE : cnt_q - ONE;
          end
        end
        default: begin
          cnt_d = cnt_q + ONE;
          up_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign count  = cnt_q;
  assign dir_up = up_q;

endmodule

// File: rtl/timer8_wave_out.sv
module timer8_wave_out
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wave_e        wave,
  input  logic [1:0]   com,
  input  logic [W-1:0] count,
  input  logic [W-1:0] top,
  input  logic [W-1:0] eff_b,
  input  logic         step_up,
  input  logic         at_top,
  output logic         pin_b,
  output logic         pin_oe
);

  logic lvl_q, lvl_d;
  logic match;
  logic connected;

  always_comb begin
    match     = (count == eff_b);
    connected = (wave != WAVE_OFF) && (com != 2'd0) &&
                !((com == 2'd1) && (wave != WAVE_NONPWM));
    lvl_d     = lvl_q;
    if (tick && connected) begin
      case (wave)
        WAVE_FAST: begin
          if (at_top)     lvl_d = ~com[0];
          else if (match) lvl_d = com[0];
        end
        WAVE_PHASE: begin
          if (match && (eff_b == top) && com[1]) lvl_d = ~com[0];
          else if (match)                       lvl_d = step_up ? com[0] : ~com[0];
        end
        default: begin
          if (match) lvl_d = (com == 2'd1) ? ~lvl_q : com[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign pin_oe = connected;
  assign pin_b  = connected & lvl_q;

endmodule

// File: rtl/timer8_wavegen.sv
module timer8_wavegen
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   com_b,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         pin_b,
  output logic         pin_oe,
  output logic         ovf_flag
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [1:0]   rst_sync_q;
  logic         rst_core_n;
  mode_cfg_t    cfg;
  logic [W-1:0] eff_a, eff_b, top;
  logic         dir_up, step_up, at_top, at_bottom;
  logic         ovf_set, flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  timer8_mode_decode u_dec (
    .mode (mode),
    .cfg  (cfg)
  );

  assign top = cfg.top_from_a ? eff_a : MAX_VAL;

  timer8_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .seq       (cfg.seq),
    .top       (top),
    .count     (count),
    .dir_up    (dir_up),
    .step_up   (step_up),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  timer8_cmp_regs #(.W(W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tick && at_top),
    .buffered (cfg.buffered),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .eff_a    (eff_a),
    .eff_b    (eff_b)
  );

  timer8_wave_out #(.W(W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick),
    .wave    (cfg.wave),
    .com     (com_b),
    .count   (count),
    .top     (top),
    .eff_b   (eff_b),
    .step_up (step_up),
    .at_top  (at_top),
    .pin_b   (pin_b),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    case (cfg.ovf)
      OVF_AT_TOP:    ovf_set = tick && at_top;
      OVF_AT_BOTTOM: ovf_set = tick && at_bottom && !dir_up;
      default:       ovf_set = tick && (count == MAX_VAL);
    endcase
    flag_d = ovf_set ? 1'b1 : (ovf_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign ovf_flag = flag_q;

endmodule

// File: rtl/timer8_wavegen_chk.sv
module timer8_wavegen_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       tick,
  input logic [2:0] mode,
  input logic [7:0] cmp_a,
  input logic [1:0] com_b,
  input logic       ovf_clr,
  input logic [7:0] count,
  input logic       pin_b,
  input logic       pin_oe,
  input logic       ovf_flag
);

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tick |=> $stable(count));

  assert_ctc_clear_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && mode == 3'd2 && count == cmp_a) |=> (count == 8'd0));

  assert_fast_set_at_top_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && mode == 3'd3 && com_b == 2'd2 && count == 8'hFF) |=> pin_b);

  assert_updown_step_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && mode == 3'd1) |=>
      ((8'(count - $past(count)) == 8'd1) || (8'($past(count) - count) == 8'd1)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_flag_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ovf_flag) |-> $past(tick));

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !pin_oe |-> !pin_b);

endmodule

bind timer8_wavegen timer8_wavegen_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .tick       (tick),
  .mode       (mode),
  .cmp_a      (cmp_a),
  .com_b      (com_b),
  .ovf_clr    (ovf_clr),
  .count      (count),
  .pin_b      (pin_b),
  .pin_oe     (pin_oe),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_timer8_wavegen.sv
`timescale 1ns/1ps
module test_timer8_wavegen;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [2:0] mode;
  logic [7:0] cmp_a, cmp_b;
  logic [1:0] com_b;
  logic       ovf_clr;
  logic [7:0] count;
  logic       pin_b, pin_oe, ovf_flag;

  int total;
  int fails;

  timer8_wavegen i_timer8_wavegen (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .com_b    (com_b),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .pin_b    (pin_b),
    .pin_oe   (pin_oe),
    .ovf_flag (ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0] md;
    logic [7:0] a;
    logic [7:0] b;
    logic [1:0] com;
    logic [9:0] n;
    logic [7:0] cnt;
    logic       pin;
    logic       oe;
    logic       flag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'd0,  8'd0,   2'd0, 10'd5,   8'd5,   1'b0, 1'b0, 1'b0},  // R1 normal
    '{3'd0, 8'd0,  8'd0,   2'd0, 10'd256, 8'd0,   1'b0, 1'b0, 1'b1},  // R1 wrap, R6 at MAX
    '{3'd2, 8'd9,  8'd0,   2'd0, 10'd10,  8'd0,   1'b0, 1'b0, 1'b0},  // R2
    '{3'd2, 8'd9,  8'd0,   2'd0, 10'd25,  8'd5,   1'b0, 1'b0, 1'b0},  // R2
    '{3'd3, 8'd0,  8'd100, 2'd2, 10'd256, 8'd0,   1'b1, 1'b1, 1'b1},  // R3 R7
    '{3'd3, 8'd0,  8'd100, 2'd2, 10'd306, 8'd50,  1'b1, 1'b1, 1'b1},  // R3 R7
    '{3'd3, 8'd0,  8'd100, 2'd2, 10'd357, 8'd101, 1'b0, 1'b1, 1'b1},  // R7 R5
    '{3'd7, 8'd19, 8'd5,   2'd3, 10'd7,   8'd6,   1'b1, 1'b1, 1'b1},  // R3 R7 R5
    '{3'd7, 8'd19, 8'd5,   2'd3, 10'd21,  8'd0,   1'b0, 1'b1, 1'b1},  // R3 R7
    '{3'd1, 8'd0,  8'd10,  2'd2, 10'd501, 8'd9,   1'b1, 1'b1, 1'b0},  // R4 R8
    '{3'd1, 8'd0,  8'd10,  2'd2, 10'd510, 8'd0,   1'b1, 1'b1, 1'b0},  // R4 R6
    '{3'd1, 8'd0,  8'd10,  2'd2, 10'd511, 8'd1,   1'b1, 1'b1, 1'b1},  // R4 R6 at BOTTOM
    '{3'd1, 8'd0,  8'd10,  2'd2, 10'd521, 8'd11,  1'b0, 1'b1, 1'b1},  // R8
    '{3'd5, 8'd5,  8'd2,   2'd3, 10'd4,   8'd3,   1'b1, 1'b1, 1'b0},  // R4 R8 R5
    '{3'd5, 8'd5,  8'd2,   2'd3, 10'd7,   8'd4,   1'b1, 1'b1, 1'b0},  // R4
    '{3'd5, 8'd5,  8'd2,   2'd3, 10'd10,  8'd1,   1'b0, 1'b1, 1'b0},  // R8
    '{3'd5, 8'd5,  8'd2,   2'd3, 10'd12,  8'd1,   1'b0, 1'b1, 1'b1},  // R6
    '{3'd5, 8'd5,  8'd5,   2'd2, 10'd12,  8'd1,   1'b1, 1'b1, 1'b1},  // R9
    '{3'd5, 8'd5,  8'd5,   2'd3, 10'd12,  8'd1,   1'b0, 1'b1, 1'b1},  // R9
    '{3'd4, 8'd0,  8'd0,   2'd2, 10'd3,   8'd3,   1'b0, 1'b0, 1'b0},  // R10 R1 reserved
    '{3'd1, 8'd0,  8'd10,  2'd1, 10'd3,   8'd3,   1'b0, 1'b0, 1'b0},  // R10
    '{3'd0, 8'd0,  8'd3,   2'd1, 10'd4,   8'd4,   1'b1, 1'b1, 1'b0}   // R10 toggle, R5 immediate
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic start(input logic [2:0] md, input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] com);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; ovf_clr = 1'b0;
    mode = md; cmp_a = a; cmp_b = b; com_b = com;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; tick = 1'b0; ovf_clr = 1'b0;
    mode = 3'd0; cmp_a = '0; cmp_b = '0; com_b = 2'd0;

    // R11 reset state
    start(3'd0, 8'd0, 8'd0, 2'd0);
    check("R11", "count", count, 0);
    check("R11", "flag", ovf_flag, 0);
    check("R11", "pin", pin_b, 0);

    // R1 no tick, no movement
    repeat (10) @(negedge clk);
    check("R1", "count idle", count, 0);

    for (int i = 0; i < NV; i++) begin
      start(VEC[i].md, VEC[i].a, VEC[i].b, VEC[i].com);
      ticks(int'(VEC[i].n));
      check($sformatf("vec%0d", i), "count", count, VEC[i].cnt);
      check($sformatf("vec%0d", i), "pin_b", pin_b, VEC[i].pin);
      check($sformatf("vec%0d", i), "pin_oe", pin_oe, VEC[i].oe);
      check($sformatf("vec%0d", i), "ovf_flag", ovf_flag, VEC[i].flag);
    end

    // R6 sticky then cleared
    start(3'd0, 8'd0, 8'd0, 2'd0);
    ticks(256);
    repeat (5) @(negedge clk);
    check("R6", "flag held", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R6", "flag cleared", ovf_flag, 0);

    // R6 mode 7 raises the flag at TOP
    start(3'd7, 8'd19, 8'd5, 2'd0);
    ticks(1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    ticks(19);
    check("R6", "mode7 before TOP", ovf_flag, 0);
    check("R3", "mode7 at TOP", count, 19);
    ticks(1);
    check("R6", "mode7 leaving TOP", ovf_flag, 1);
    check("R3", "mode7 wrap", count, 0);

    // R5 fast mode: a new B mid-period waits for the next TOP
    start(3'd3, 8'd0, 8'd100, 2'd2);
    ticks(306);
    cmp_b = 8'd60;
    ticks(30);
    check("R5", "pin after old-B point", pin_b, 1);
    check("R5", "count", count, 80);
    ticks(21);
    check("R5", "pin at active B", pin_b, 0);

    summary();
    $finish;
  end

endmodule